// File: doc/BRIEF.md
# Carry-select adder stage with increment-derived upper result

A combinational adder stage of parameterised width that adds two unsigned operands and a carry input, and produces a sum word and a carry output. A single ripple-carry chain computes the result that holds when the incoming carry is zero.

The result for an incoming carry of one is not computed by a second adder. An increment chain adds one to the zero-carry sum word. A two-way select then picks one of the two results, each being the sum word together with its carry, using the actual carry input.

The stage is meant to be chained, with stages of growing width, into larger select adders. It holds no state and has no clock or reset.

Top module: `csel_inc_adder`

## Requirements
- R1: For every operand pair and carry input, {cout_o, sum_o} equals a_i + b_i + cin_i, taken as an unsigned value of WIDTH+1 bits.
- R2: With cin_i = 0, the outputs equal the unsigned sum a_i + b_i. These are the ripple chain's sum and carry-out with its carry-in tied low.
- R3: With cin_i = 1, the outputs equal a_i + b_i + 1. This result comes from incrementing the zero-carry sum word, and not from a second adder.
- R4: Bit 0 of sum_o equals a_i[0] XOR b_i[0] XOR cin_i.
- R5: With cin_i = 1 and a_i + b_i = 2^WIDTH - 1 (all-ones sum word), sum_o wraps to zero and cout_o is 1.
- R6: With cin_i = 1, cout_o is 1 exactly when a_i + b_i >= 2^WIDTH - 1. This covers both a carry out of the ripple chain and an increment that runs through every bit.
- R7: The outputs depend only on the present inputs. A change of inputs shows up at the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| cin_i | input | 1 | Carry input; selects between the two precomputed results |
| sum_o | output | WIDTH | Sum word |
| cout_o | output | 1 | Carry output |

## Verification
The hardest case to reach is an increment carry that runs the full length of the chain. This happens only when the zero-carry sum word is all ones. At 16 bits, random operands almost never produce that.

The bench therefore sweeps every operand pair and both carry values on a 4-bit instance, which covers all such words. On the 16-bit instance it adds directed pairs whose sum is 2^16 - 1, and pairs that overflow, ahead of the random vectors.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int unsigned MIN_WIDTH = 2;

  typedef enum logic {
    SEL_CARRY_ZERO = 1'b0,
    SEL_CARRY_ONE  = 1'b1
  } carry_sel_e;
endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic half_sum;
    logic half_carry;
    assign half_sum     = a_i[i] ^ b_i[i];
    assign half_carry   = a_i[i] & b_i[i];
    assign sum_o[i]     = half_sum ^ carry[i];
    assign carry[i+1]   = half_carry | (half_sum & carry[i]);
  end

  assign cout_o = carry[WIDTH];
endmodule

// File: rtl/csel_incr.sv
module csel_incr #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] base_sum_i,
  input  logic             base_cout_i,
  output logic [WIDTH-1:0] inc_sum_o,
  output logic             inc_cout_o
);
  logic [WIDTH-1:0] run;

  assign inc_sum_o[0] = ~base_sum_i[0];
  assign run[0]       = base_sum_i[0];

  for (genvar i = 1; i < WIDTH; i++) begin : g_bit
    assign inc_sum_o[i] = base_sum_i[i] ^ run[i-1];
    assign run[i]       = base_sum_i[i] & run[i-1];
  end

  // both set is unreachable: max a+b leaves sum word not all ones
  assign inc_cout_o = base_cout_i ^ run[WIDTH-1];
endmodule

// File: rtl/csel_pick.sv
module csel_pick #(
  parameter int unsigned WIDTH = 17
) (
  input  logic [WIDTH-1:0] zero_i,
  input  logic [WIDTH-1:0] one_i,
  input  logic             sel_i,
  output logic [WIDTH-1:0] res_o
);
  import csel_pkg::*;

  carry_sel_e sel;
  assign sel = carry_sel_e'(sel_i);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign res_o[i] = (sel == SEL_CARRY_ONE) ? one_i[i] : zero_i[i];
  end
endmodule

// File: rtl/csel_inc_adder.sv
module csel_inc_adder #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  import csel_pkg::*;

  localparam int unsigned RES_W = WIDTH + 1;

  logic [WIDTH-1:0] sum0, sum1;
  logic             cout0, cout1;
  logic [RES_W-1:0] res;

  if (WIDTH < MIN_WIDTH) begin : g_bad_width
    initial $fatal(1, "csel_inc_adder: WIDTH below minimum");
  end

  csel_ripple #(.WIDTH(WIDTH)) u_ripple (
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_o  (sum0),
    .cout_o (cout0)
  );

  csel_incr #(.WIDTH(WIDTH)) u_incr (
    .base_sum_i  (sum0),
    .base_cout_i (cout0),
    .inc_sum_o   (sum1),
    .inc_cout_o  (cout1)
  );

  csel_pick #(.WIDTH(RES_W)) u_pick (
    .zero_i ({cout0, sum0}),
    .one_i  ({cout1, sum1}),
    .sel_i  (cin_i),
    .res_o  (res)
  );

  assign sum_o  = res[WIDTH-1:0];
  assign cout_o = res[WIDTH];
endmodule

// File: rtl/csel_inc_adder_chk.sv
module csel_inc_adder_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic [WIDTH-1:0] sum0,
  input logic             cout0,
  input logic [WIDTH-1:0] sum1,
  input logic             cout1
);
  logic [WIDTH:0] total, base, base_inc;
  logic           known;

  always_comb begin
    total    = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    base     = {cout0, sum0};
    base_inc = base + 1'b1;
    known    = !$isunknown({a_i, b_i, cin_i, sum_o, cout_o, sum0, cout0, sum1, cout1});
    if (known) begin
      // R1
      total_match_chk: assert ({cout_o, sum_o} == total);
      // R2
      zero_path_chk: assert (cin_i || ({cout_o, sum_o} == base));
      // R3
      incr_path_chk: assert ({cout1, sum1} == base_inc);
      // R4
      lsb_chk: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i));
      // R6
      incr_cout_chk: assert (cout1 == (cout0 | (&sum0)));
    end
  end
endmodule

bind csel_inc_adder csel_inc_adder_chk #(.WIDTH(WIDTH)) i_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .sum0   (sum0),
  .cout0  (cout0),
  .sum1   (sum1),
  .cout1  (cout1)
);

// File: tb/test_csel_inc_adder.sv
module test_csel_inc_adder;
  localparam int unsigned NS = 4;
  localparam int unsigned NW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  logic [NS-1:0] a_s, b_s, sum_s;
  logic          cin_s, cout_s;
  logic [NW-1:0] a_w, b_w, sum_w;
  logic          cin_w, cout_w;

  always #5 clk = ~clk;

  csel_inc_adder #(.WIDTH(NS)) i_csel_inc_adder (
    .a_i(a_s), .b_i(b_s), .cin_i(cin_s), .sum_o(sum_s), .cout_o(cout_s)
  );

  csel_inc_adder #(.WIDTH(NW)) i_csel_inc_adder_wide (
    .a_i(a_w), .b_i(b_w), .cin_i(cin_w), .sum_o(sum_w), .cout_o(cout_w)
  );

  task automatic check(input string req, input logic [NW:0] act, input logic [NW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_small(input int a, input int b, input int c);
    logic [NS:0] exp;
    @(posedge clk);
    a_s = NS'(a); b_s = NS'(b); cin_s = c[0];
    @(negedge clk);
    exp = NS'(a) + NS'(b) + c[0];
    exp = (NS+1)'(a) + (NS+1)'(b) + (NS+1)'(c[0]);
    check("R1", (NW+1)'({cout_s, sum_s}), (NW+1)'(exp));
    check("R4", (NW+1)'(sum_s[0]), (NW+1)'(a[0] ^ b[0] ^ c[0]));
    if (c[0]) check("R6", (NW+1)'(cout_s), (NW+1)'((a + b) >= ((1 << NS) - 1)));
    else      check("R2", (NW+1)'({cout_s, sum_s}), (NW+1)'(a + b));
  endtask

  task automatic run_wide(input logic [NW-1:0] a, input logic [NW-1:0] b, input logic c, input string req);
    logic [NW:0] exp;
    @(posedge clk);
    a_w = a; b_w = b; cin_w = c;
    @(negedge clk);
    exp = {1'b0, a} + {1'b0, b} + {{NW{1'b0}}, c};
    check(req, {cout_w, sum_w}, exp);
  endtask

  initial begin
    a_s = '0; b_s = '0; cin_s = 1'b0;
    a_w = '0; b_w = '0; cin_w = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R2 idle", {cout_w, sum_w}, '0);

    // R7: input change with no clock edge between
    a_w = 16'h00ff; b_w = 16'h0001; cin_w = 1'b0;
    #1;
    check("R7", {cout_w, sum_w}, 17'h00100);
    a_w = 16'h1234; cin_w = 1'b1;
    #1;
    check("R7", {cout_w, sum_w}, 17'h01236);

    // R5 full increment run on wide instance
    run_wide(16'hffff, 16'h0000, 1'b1, "R5");
    run_wide(16'h8000, 16'h7fff, 1'b1, "R5");
    run_wide(16'h1234, 16'hedcb, 1'b1, "R5");
    run_wide(16'h8000, 16'h7fff, 1'b0, "R2");
    run_wide(16'hffff, 16'hffff, 1'b1, "R6");
    run_wide(16'hffff, 16'hffff, 1'b0, "R2");
    run_wide(16'h8000, 16'h8000, 1'b1, "R3");

    // exhaustive small instance: R1 R2 R4 R6, wrap case R5 included
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < (1 << NS); a++)
        for (int b = 0; b < (1 << NS); b++)
          run_small(a, b, c);

    // R3 and R1 on random wide vectors
    for (int k = 0; k < 2000; k++)
      run_wide(NW'($urandom), NW'($urandom), k[0], k[0] ? "R3" : "R1");

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule